// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 18-bit bidirectional buses, called A and B, with one storage word for each direction of transfer. Each storage word is built from a level-sensitive latch merged with a register that loads on the falling edge of a clock. The latch-enable level and the clock activity together choose the behaviour. With the latch enable high, the stored word follows its source bus. With the latch enable low and the clock idle at either level, the word holds. With the latch enable low, a falling clock edge captures the source bus.

The A-to-B direction has an output enable, a latch enable and a clock of its own. The B-to-A direction has a matching set of its own. When a direction's output enable is active, its stored word is driven onto the far bus; otherwise that bus is released to high impedance. The A-to-B output enable is active high and the B-to-A output enable is active low. Both directions may drive at the same time, and each then drives only its own destination bus. An active-low reset clears both stored words so that tests start from a known state.

Top module: `reg_bus_xcvr`

## Requirements
- R1: Each direction carries 18 independent bits. Bit i of the source bus reaches only bit i of the destination bus, so one-hot, alternating and all-ones patterns pass unchanged.
- R2: While `a2b_le` is 1 and `a2b_oe` is 1, `port_b` follows `port_a` with no clock activity. A clock pulse during this time does not disturb that.
- R3: While `a2b_le` is 0 and `a2b_clk` stays at one level (low or high), changes on `port_a` do not reach `port_b`.
- R4: A low-to-high transition of `a2b_clk` with `a2b_le` at 0 does not load `port_a` into storage.
- R5: A high-to-low transition of `a2b_clk` with `a2b_le` at 0 loads the present `port_a` value, which then appears on `port_b`.
- R6: When `a2b_le` falls while `a2b_clk` is idle, the stored word keeps the last value seen in transparent mode.
- R7: `a2b_oe` is active high. At 0, `port_b` is high impedance in all 18 bits. Turning the enable off and back on leaves the stored word unchanged.
- R8: The B-to-A direction behaves as R2 to R6, using `b2a_le` and `b2a_clk`, with `port_b` as source and `port_a` as destination.
- R9: `b2a_oe_n` is active low. At 1, `port_a` is high impedance in all 18 bits. Turning the enable off and back on leaves the stored word unchanged.
- R10: With `a2b_oe` at 1 and `b2a_oe_n` at 0 together, and both latch enables at 0, `port_b` shows the A-to-B stored word and `port_a` shows the B-to-A stored word, each independent of the other.
- R11: `rst_n` at 0 clears both stored words to zero at once, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of both stored words |
| a2b_oe | input | 1 | Active-high drive enable for the A-to-B word onto `port_b` |
| a2b_le | input | 1 | A-to-B latch enable; 1 selects transparent mode |
| a2b_clk | input | 1 | A-to-B capture clock; loads on its falling edge |
| b2a_oe_n | input | 1 | Active-low drive enable for the B-to-A word onto `port_a` |
| b2a_le | input | 1 | B-to-A latch enable; 1 selects transparent mode |
| b2a_clk | input | 1 | B-to-A capture clock; loads on its falling edge |
| port_a | inout | 18 | Bus A: source of A-to-B, destination of B-to-A |
| port_b | inout | 18 | Bus B: source of B-to-A, destination of A-to-B |

## Verification
The hardest case to reach is telling a rising-edge load from a falling-edge load. In both cases the destination ends up showing some source value, so the stimulus changes the source between the two clock edges and samples the destination after each edge separately. A second subtle case is a latch-enable fall with the clock idle. To make it visible, the source is changed right after the fall, so a design that kept an older register value or tracked the bus would show the wrong word. Driving both directions at once needs the bench to release its own drivers on both buses first, after loading each direction with a distinct word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Default data width of each transfer direction.
    localparam int unsigned XCVR_W = 18;

    // Per-bit storage state.
    typedef struct packed {
        logic held;
    } slice_st_t;

endpackage

// File: rtl/xcvr_slice.sv
// One bit of storage: a falling-edge register merged with a transparent latch.
module xcvr_slice
    import xcvr_pkg::*;
(
    input  logic rst_n,
    input  logic le,
    input  logic clk,
    input  logic din,
    output logic dout
);

    slice_st_t st_d;
    slice_st_t st_q;

    // Next value: always the live input. The register only updates on a
    // falling clock or on the close of a transparent window.
    always_comb begin
        st_d      = st_q;
        st_d.held = din;
    end

    // The falling edge of le also loads, so that closing the latch with the
    // clock idle keeps the last value that was passed through.
    always_ff @(negedge clk or negedge le or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Transparent when le is high, stored value otherwise.
    always_comb begin
        dout = le ? din : st_q.held;
    end

endmodule

// File: rtl/xcvr_path.sv
// One transfer direction: W replicated storage slices.
module xcvr_path #(
    parameter int W = 18
) (
    input  logic         rst_n,
    input  logic         le,
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        xcvr_slice u_slice (
            .rst_n (rst_n),
            .le    (le),
            .clk   (clk),
            .din   (din[i]),
            .dout  (dout[i])
        );
    end

endmodule

// File: rtl/xcvr_tri.sv
// Tri-state bus driver for one destination bus.
module xcvr_tri #(
    parameter int W = 18
) (
    input  logic         en,
    input  logic [W-1:0] data,
    inout  wire  [W-1:0] bus
);

    assign bus = en ? data : {W{1'bz}};

endmodule

// File: rtl/reg_bus_xcvr.sv
// Registered bidirectional bus transceiver, top level.
module reg_bus_xcvr #(
    parameter int W = xcvr_pkg::XCVR_W
) (
    input  logic         rst_n,
    input  logic         a2b_oe,
    input  logic         a2b_le,
    input  logic         a2b_clk,
    input  logic         b2a_oe_n,
    input  logic         b2a_le,
    input  logic         b2a_clk,
    inout  wire  [W-1:0] port_a,
    inout  wire  [W-1:0] port_b
);

    logic [W-1:0] a2b_word;
    logic [W-1:0] b2a_word;
    logic         b2a_en;

    assign b2a_en = ~b2a_oe_n;

    // A-to-B storage, sourced from bus A.
    xcvr_path #(.W(W)) u_a2b (
        .rst_n (rst_n),
        .le    (a2b_le),
        .clk   (a2b_clk),
        .din   (port_a),
        .dout  (a2b_word)
    );

    // B-to-A storage, sourced from bus B.
    xcvr_path #(.W(W)) u_b2a (
        .rst_n (rst_n),
        .le    (b2a_le),
        .clk   (b2a_clk),
        .din   (port_b),
        .dout  (b2a_word)
    );

    xcvr_tri #(.W(W)) u_drv_b (
        .en   (a2b_oe),
        .data (a2b_word),
        .bus  (port_b)
    );

    xcvr_tri #(.W(W)) u_drv_a (
        .en   (b2a_en),
        .data (b2a_word),
        .bus  (port_a)
    );

    // R2
    a2b_transparent_chk: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        (a2b_le && a2b_oe) |-> (port_b == port_a));

    // R8
    b2a_transparent_chk: assert property (@(posedge b2a_clk) disable iff (!rst_n)
        (b2a_le && !b2a_oe_n) |-> (port_a == port_b));

    // R7
    a2b_drive_known_chk: assert property (@(posedge a2b_clk) disable iff (!rst_n)
        a2b_oe |-> !$isunknown(port_b));

    // R9
    b2a_drive_known_chk: assert property (@(posedge b2a_clk) disable iff (!rst_n)
        !b2a_oe_n |-> !$isunknown(port_a));

endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;

    localparam int W = 18;
    localparam logic [W-1:0] HIZ = {W{1'bz}};

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz pacing clock

    logic rst_n    = 1'b1;
    logic a2b_oe   = 1'b0;
    logic a2b_le   = 1'b0;
    logic a2b_clk  = 1'b0;
    logic b2a_oe_n = 1'b1;
    logic b2a_le   = 1'b0;
    logic b2a_clk  = 1'b0;

    logic [W-1:0] a_drv = '0;
    logic [W-1:0] b_drv = '0;
    logic         a_drv_en = 1'b0;
    logic         b_drv_en = 1'b0;

    wire [W-1:0] port_a;
    wire [W-1:0] port_b;

    assign port_a = a_drv_en ? a_drv : HIZ;
    assign port_b = b_drv_en ? b_drv : HIZ;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    reg_bus_xcvr #(.W(W)) dut (
        .rst_n    (rst_n),
        .a2b_oe   (a2b_oe),
        .a2b_le   (a2b_le),
        .a2b_clk  (a2b_clk),
        .b2a_oe_n (b2a_oe_n),
        .b2a_le   (b2a_le),
        .b2a_clk  (b2a_clk),
        .port_a   (port_a),
        .port_b   (port_b)
    );

    // Inputs change and outputs are sampled 2 ns after a pacing edge.
    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ba = 0: A-to-B direction, ba = 1: B-to-A direction.
    task automatic set_le(input bit ba, input logic v);
        if (ba) b2a_le = v; else a2b_le = v;
    endtask

    task automatic set_clk(input bit ba, input logic v);
        if (ba) b2a_clk = v; else a2b_clk = v;
    endtask

    task automatic set_oe(input bit ba, input bit on);
        if (ba) b2a_oe_n = !on; else a2b_oe = on;
    endtask

    task automatic drive_src(input bit ba, input logic [W-1:0] v);
        if (ba) begin b_drv = v; b_drv_en = 1'b1; end
        else    begin a_drv = v; a_drv_en = 1'b1; end
    endtask

    function automatic logic [W-1:0] dst(input bit ba);
        return ba ? port_a : port_b;
    endfunction

    // R11: asynchronous clear, seen with both directions driving.
    task automatic t_reset();
        a_drv_en = 1'b0; b_drv_en = 1'b0;
        a2b_le = 1'b0; b2a_le = 1'b0;
        a2b_oe = 1'b1; b2a_oe_n = 1'b0;
        rst_n = 1'b0;
        settle();
        check("R11 reset clears A-to-B word", port_b, '0);
        check("R11 reset clears B-to-A word", port_a, '0);
        rst_n = 1'b1;
        a2b_oe = 1'b0; b2a_oe_n = 1'b1;
        settle();
    endtask

    // R1, R2, R8: transparent mode.
    task automatic t_transparent(input bit ba);
        logic [W-1:0] pats [5];
        pats[0] = 18'h00001; pats[1] = 18'h20000; pats[2] = 18'h2AAAA;
        pats[3] = 18'h15555; pats[4] = 18'h3FFFF;
        set_oe(ba, 1'b1);
        set_le(ba, 1'b1);
        for (int i = 0; i < 5; i++) begin
            drive_src(ba, pats[i]);
            settle();
            check(ba ? "R8 R1 transparent B-to-A" : "R2 R1 transparent A-to-B", dst(ba), pats[i]);
        end
        drive_src(ba, 18'h0A5A5);
        settle();
        set_clk(ba, 1'b1);
        settle();
        set_clk(ba, 1'b0);
        settle();
        check(ba ? "R8 transparent with clock pulse" : "R2 transparent with clock pulse", dst(ba), 18'h0A5A5);
    endtask

    // R6, R8: closing the latch with the clock idle.
    task automatic t_le_fall(input bit ba);
        drive_src(ba, 18'h0F0F0);
        settle();
        set_le(ba, 1'b0);
        settle();
        drive_src(ba, 18'h3C3C3);
        settle();
        check(ba ? "R8 latch close keeps last value" : "R6 latch close keeps last value", dst(ba), 18'h0F0F0);
    endtask

    // R3, R4, R5, R8: hold and edge capture.
    task automatic t_edges(input bit ba);
        drive_src(ba, 18'h12345);
        settle();
        set_clk(ba, 1'b1);
        settle();
        check(ba ? "R8 no load on rising edge" : "R4 no load on rising edge", dst(ba), 18'h0F0F0);
        drive_src(ba, 18'h2BCDE);
        settle();
        set_clk(ba, 1'b0);
        settle();
        check(ba ? "R8 load on falling edge" : "R5 load on falling edge", dst(ba), 18'h2BCDE);
        drive_src(ba, 18'h01234);
        settle();
        check(ba ? "R8 hold with clock low" : "R3 hold with clock low", dst(ba), 18'h2BCDE);
        set_clk(ba, 1'b1);
        settle();
        check(ba ? "R8 no load on second rising edge" : "R4 no load on second rising edge", dst(ba), 18'h2BCDE);
        drive_src(ba, 18'h3FFFF);
        settle();
        check(ba ? "R8 hold with clock high" : "R3 hold with clock high", dst(ba), 18'h2BCDE);
        set_clk(ba, 1'b0);
        settle();
        check(ba ? "R8 load all ones on falling edge" : "R5 load all ones on falling edge", dst(ba), 18'h3FFFF);
    endtask

    // R7, R9: release of the destination bus.
    task automatic t_hiz(input bit ba);
        drive_src(ba, 18'h00000);
        set_oe(ba, 1'b0);
        settle();
        check(ba ? "R9 port_a released when b2a_oe_n=1" : "R7 port_b released when a2b_oe=0", dst(ba), HIZ);
        set_oe(ba, 1'b1);
        settle();
        check(ba ? "R9 word kept across disable" : "R7 word kept across disable", dst(ba), 18'h3FFFF);
        set_oe(ba, 1'b0);
        a_drv_en = 1'b0; b_drv_en = 1'b0;
        settle();
    endtask

    task automatic run_path(input bit ba);
        t_transparent(ba);
        t_le_fall(ba);
        t_edges(ba);
        t_hiz(ba);
    endtask

    // R10: both directions driving at once.
    task automatic t_both();
        a2b_oe = 1'b0; b2a_oe_n = 1'b1;
        drive_src(1'b0, 18'h2468A);
        drive_src(1'b1, 18'h13579);
        a2b_le = 1'b1; b2a_le = 1'b1;
        settle();
        a2b_le = 1'b0; b2a_le = 1'b0;
        settle();
        a_drv_en = 1'b0; b_drv_en = 1'b0;
        settle();
        a2b_oe = 1'b1; b2a_oe_n = 1'b0;
        settle();
        check("R10 port_b from A-to-B word", port_b, 18'h2468A);
        check("R10 port_a from B-to-A word", port_a, 18'h13579);
        a2b_oe = 1'b0; b2a_oe_n = 1'b1;
        settle();
    endtask

    initial begin
        settle();
        t_reset();
        run_path(1'b0);
        run_path(1'b1);
        t_both();
        t_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL all: watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule